// File: doc/BRIEF.md
# Grouped GPIO interrupt controller

This block watches a wide bank of general-purpose input pins through only eight interrupt groups. Each group has a 4-bit selector that picks one bank of eight pins. Within that bank, group `g` always watches the pin in position `g`. Each group also has a 3-bit trigger code. The code chooses between off, level-high, level-low, a constant-asserted mode, and rising, falling or either-edge detection.

Edge events are held in a sticky pending latch until software clears it by writing a one to the acknowledge register. Level and constant modes report the live condition instead. A per-group mask gates the raw status into a masked status word. The OR of the masked status drives a single registered interrupt line.

Software reaches the block through a simple 32-bit register bus. The bus has a byte address, a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `gpio_group_irq`

## Requirements
- R1: After reset, the configuration, routing and mask registers read zero, both status words read zero, and `irq_o` is low.
- R2: The configuration register is at byte offset 120 and holds 24 bits, 3 per group. The routing register is at 124 and holds 32 bits, 4 per group. The mask register is at 128 and holds 8 bits. Each reads back what was written, with the unused upper bits reading zero.
- R3: Group `g` watches input pin `8*s + g`, where `s` is routing bits `[4g+3:4g]`.
- R4: Trigger code 1 (level high) and trigger code 2 (level low) set the group's raw status bit from the live, synchronized pin value. Acknowledge does not clear these modes.
- R5: Trigger code 3 holds the raw status bit at one. Codes 0 and 4 hold it at zero.
- R6: Edge modes set a sticky raw status bit. Code 5 sets it on a rising edge, code 6 on a falling edge and code 7 on either edge. The bit stays set after the pin returns to its old level. The raw status word is read at offset 136, with group `g` at bit `g`.
- R7: Writing offset 132 with bit `g` set clears the pending edge bit of group `g`. Bits written as zero leave their groups untouched.
- R8: If an edge is detected in the same cycle as an acknowledge of that group, the pending bit stays set.
- R9: The masked status word at offset 140 equals the raw status ANDed with the mask. Its bits 31:8 read zero.
- R10: `irq_o` is the OR of the masked status bits, registered, so it follows the masked status one cycle later.
- R11: While a group's code is 0 or 4, its stored previous pin value is frozen. A pin that changed while the group was off is therefore seen as an edge once an edge mode is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| pins_i | input | NUM_SEL*8 (128) | Asynchronous GPIO inputs |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench lines up an acknowledge write with the exact cycle in which a second edge is detected. A design that gives the acknowledge priority would silently drop that event. It routes a group to a remote pin bank and toggles the pin that sits in the same bank position but is not routed. A routing decoder that ignored the selector would then react to the wrong pin. It acknowledges level-mode groups to show their status cannot be wiped, and writes partial acknowledge masks to show that untouched groups keep their pending bits. It also enables an edge mode after the pin moved while the group was off. A design that kept sampling while off would miss the edge that the frozen history requires.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int MODE_W  = 3;
  localparam int SEL_W   = 4;

  localparam logic [ADDR_W-1:0] OFS_CFG    = 8'd120;
  localparam logic [ADDR_W-1:0] OFS_ROUTE  = 8'd124;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'd128;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 8'd132;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 8'd136;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 8'd140;

  typedef enum logic [MODE_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_SET  = 3'd3,
    TRIG_RSV  = 3'd4,
    TRIG_RISE = 3'd5,
    TRIG_FALL = 3'd6,
    TRIG_ANY  = 3'd7
  } trig_e;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_GRP = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [BUS_W-1:0]          bus_wdata,
  input  logic                      bus_rd,
  output logic [BUS_W-1:0]          bus_rdata,
  input  logic [NUM_GRP-1:0]        raw_i,
  output logic [NUM_GRP*MODE_W-1:0] cfg_o,
  output logic [NUM_GRP*SEL_W-1:0]  route_o,
  output logic [NUM_GRP-1:0]        mask_o,
  output logic [NUM_GRP-1:0]        masked_o,
  output logic [NUM_GRP-1:0]        ack_o
);
  localparam int CFG_W   = NUM_GRP * MODE_W;
  localparam int ROUTE_W = NUM_GRP * SEL_W;

  logic [CFG_W-1:0]   cfg_q;
  logic [ROUTE_W-1:0] route_q;
  logic [NUM_GRP-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      route_q <= '0;
      mask_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_CFG:   cfg_q   <= bus_wdata[CFG_W-1:0];
        OFS_ROUTE: route_q <= bus_wdata[ROUTE_W-1:0];
        OFS_MASK:  mask_q  <= bus_wdata[NUM_GRP-1:0];
        default:   ;
      endcase
    end
  end

  assign masked_o = raw_i & mask_q;
  assign ack_o    = (bus_wr && bus_addr == OFS_ACK) ? bus_wdata[NUM_GRP-1:0] : '0;
  assign cfg_o    = cfg_q;
  assign route_o  = route_q;
  assign mask_o   = mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_CFG:    bus_rdata <= BUS_W'(cfg_q);
        OFS_ROUTE:  bus_rdata <= BUS_W'(route_q);
        OFS_MASK:   bus_rdata <= BUS_W'(mask_q);
        OFS_RAW:    bus_rdata <= BUS_W'(raw_i);
        OFS_MASKED: bus_rdata <= BUS_W'(masked_o);
        default:    bus_rdata <= '0;
      endcase
    end
  end

  // R1: configuration state returns to zero after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cfg_q == '0 && route_q == '0 && mask_q == '0));

  // R9: masked status read never carries upper bits
  p_masked_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_MASKED) |=> (bus_rdata[BUS_W-1:NUM_GRP] == '0));
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group
  import gpio_irq_pkg::*;
#(
  parameter int NUM_SEL = 16,
  parameter int NUM_GRP = 8,
  parameter int GIDX    = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SEL*NUM_GRP-1:0] pins_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [MODE_W-1:0]          mode_i,
  input  logic                       ack_i,
  output logic                       raw_o
);
  localparam int NPIN = NUM_SEL * NUM_GRP;

  logic picked;
  logic sync1_q, sync2_q, prev_q, pend_q;
  logic is_off, is_edge, rise, fall, hit;

  always_comb begin
    picked = 1'b0;
    for (int s = 0; s < NUM_SEL; s++)
      if (sel_i == SEL_W'(s)) picked = pins_i[s*NUM_GRP + GIDX];
  end

  assign is_off  = (mode_i[1:0] == 2'b00);
  assign is_edge = mode_i[2] && !is_off;
  assign rise    = sync2_q && !prev_q;
  assign fall    = !sync2_q && prev_q;
  assign hit     = ((mode_i == TRIG_RISE) && rise) ||
                   ((mode_i == TRIG_FALL) && fall) ||
                   ((mode_i == TRIG_ANY)  && (rise || fall));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      sync1_q <= picked;
      sync2_q <= sync1_q;
      if (!is_off) prev_q <= sync2_q;
      if (!is_edge)    pend_q <= 1'b0;
      else if (hit)    pend_q <= 1'b1;
      else if (ack_i)  pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (mode_i)
      TRIG_HIGH: raw_o = sync2_q;
      TRIG_LOW:  raw_o = !sync2_q;
      TRIG_SET:  raw_o = 1'b1;
      TRIG_RISE, TRIG_FALL, TRIG_ANY: raw_o = pend_q;
      default:   raw_o = 1'b0;
    endcase
  end

  // R6: a pending edge survives until acknowledged
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !ack_i && is_edge) |=> pend_q);

  // R8: a detected edge always lands in the latch, acknowledge or not
  p_edge_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (is_edge && hit) |=> pend_q);

  // R5: off codes never report status
  p_off_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    is_off |-> !raw_o);
endmodule

// File: rtl/gpio_group_irq.sv
module gpio_group_irq
  import gpio_irq_pkg::*;
#(
  parameter int NUM_SEL = 16,
  parameter int NUM_GRP = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [BUS_W-1:0]           bus_wdata,
  input  logic                       bus_rd,
  output logic [BUS_W-1:0]           bus_rdata,
  input  logic [NUM_SEL*NUM_GRP-1:0] pins_i,
  output logic                       irq_o
);
  logic [NUM_GRP*MODE_W-1:0] cfg;
  logic [NUM_GRP*SEL_W-1:0]  route;
  logic [NUM_GRP-1:0]        mask, masked, ack, raw;
  logic                      irq_q;

  gpio_irq_regs #(.NUM_GRP(NUM_GRP)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .raw_i(raw), .cfg_o(cfg), .route_o(route), .mask_o(mask),
    .masked_o(masked), .ack_o(ack)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    gpio_irq_group #(.NUM_SEL(NUM_SEL), .NUM_GRP(NUM_GRP), .GIDX(g)) u_grp (
      .clk(clk), .rst(rst), .pins_i(pins_i),
      .sel_i(route[g*SEL_W +: SEL_W]),
      .mode_i(cfg[g*MODE_W +: MODE_W]),
      .ack_i(ack[g]),
      .raw_o(raw[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |masked;
  end
  assign irq_o = irq_q;

  // R10: interrupt line trails the masked status by one cycle
  p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|masked)));

  // R9: masked status is a subset of the mask
  p_masked_subset_r9: assert property (@(posedge clk) disable iff (rst)
    ((masked & ~mask) == '0));
endmodule

// File: tb/gpio_group_irq_bench.sv
`timescale 1ns/1ps
module gpio_group_irq_bench;
  localparam int NSEL = 16;
  localparam int NG   = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_rd = 1'b0;
  logic [31:0]  bus_rdata;
  logic [NSEL*NG-1:0] pins = '0;
  logic         irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gpio_group_irq #(.NUM_SEL(NSEL), .NUM_GRP(NG)) u_gpio_group_irq (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pins_i(pins), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    rd(8'd120, d); chk("R1 cfg", d, 32'd0);
    rd(8'd124, d); chk("R1 route", d, 32'd0);
    rd(8'd128, d); chk("R1 mask", d, 32'd0);
    rd(8'd136, d); chk("R1 raw", d, 32'd0);
    rd(8'd140, d); chk("R1 masked", d, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'd120, 32'hFFFF_FFFF); rd(8'd120, d); chk("R2 cfg", d, 32'h00FF_FFFF);
    wr(8'd124, 32'hA5A5_A5A5); rd(8'd124, d); chk("R2 route", d, 32'hA5A5_A5A5);
    wr(8'd128, 32'h0000_01FF); rd(8'd128, d); chk("R2 mask", d, 32'h0000_00FF);
    wr(8'd120, 0); wr(8'd124, 0); wr(8'd128, 0);
    settle();
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(8'd120, 32'd1 << 6);
    pins[2] = 1'b1; settle();
    rd(8'd136, d); chk("R4 high active", d, 32'h04);
    wr(8'd132, 32'h04); rd(8'd136, d); chk("R4 ack no effect", d, 32'h04);
    pins[2] = 1'b0; settle();
    rd(8'd136, d); chk("R4 high idle", d, 32'h00);
    wr(8'd120, 32'd2 << 6); settle();
    rd(8'd136, d); chk("R4 low active", d, 32'h04);
    wr(8'd120, 0); settle();
  endtask

  task automatic t_const();
    logic [31:0] d;
    wr(8'd120, 32'd3); settle();
    rd(8'd136, d); chk("R5 set", d, 32'h01);
    pins[0] = 1'b1; wr(8'd120, 32'd4); settle();
    rd(8'd136, d); chk("R5 code4 off", d, 32'h00);
    wr(8'd120, 32'd0); settle();
    rd(8'd136, d); chk("R5 code0 off", d, 32'h00);
    pins[0] = 1'b0; settle();
  endtask

  task automatic t_route();
    logic [31:0] d;
    wr(8'd124, 32'd3 << 20);
    wr(8'd120, 32'd1 << 15);
    pins[5] = 1'b1; settle();
    rd(8'd136, d); chk("R3 unrouted pin", d, 32'h00);
    pins[29] = 1'b1; settle();
    rd(8'd136, d); chk("R3 routed pin 29", d, 32'h20);
    wr(8'd124, 32'd15 << 20); settle();
    rd(8'd136, d); chk("R3 sel15 idle", d, 32'h00);
    pins[125] = 1'b1; settle();
    rd(8'd136, d); chk("R3 routed pin 125", d, 32'h20);
    pins[5] = 1'b0; pins[29] = 1'b0; pins[125] = 1'b0;
    wr(8'd120, 0); wr(8'd124, 0); settle();
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(8'd120, 32'd5 << 3); settle();
    pins[1] = 1'b1; settle();
    rd(8'd136, d); chk("R6 rise", d, 32'h02);
    pins[1] = 1'b0; settle();
    rd(8'd136, d); chk("R6 sticky", d, 32'h02);
    wr(8'd132, 32'hFD); rd(8'd136, d); chk("R7 other bits kept", d, 32'h02);
    wr(8'd132, 32'h02); rd(8'd136, d); chk("R7 cleared", d, 32'h00);
    wr(8'd120, 32'd6 << 3);
    pins[1] = 1'b1; settle();
    rd(8'd136, d); chk("R6 fall ignores rise", d, 32'h00);
    pins[1] = 1'b0; settle();
    rd(8'd136, d); chk("R6 fall", d, 32'h02);
    wr(8'd132, 32'h02);
    wr(8'd120, 32'd7 << 3);
    pins[1] = 1'b1; settle();
    rd(8'd136, d); chk("R6 any rise", d, 32'h02);
    wr(8'd132, 32'h02);
    pins[1] = 1'b0; settle();
    rd(8'd136, d); chk("R6 any fall", d, 32'h02);
    wr(8'd132, 32'h02); wr(8'd120, 0); settle();
  endtask

  task automatic t_mask_irq();
    logic [31:0] d;
    wr(8'd120, 32'd1 << 12);
    pins[4] = 1'b1; settle();
    rd(8'd140, d); chk("R9 masked off", d, 32'h00);
    chk("R10 irq low", {31'd0, irq_o}, 32'd0);
    wr(8'd128, 32'h10);
    chk("R10 irq one cycle later", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    chk("R10 irq high", {31'd0, irq_o}, 32'd1);
    rd(8'd140, d); chk("R9 masked on", d, 32'h10);
    pins[4] = 1'b0; settle();
    chk("R10 irq drops", {31'd0, irq_o}, 32'd0);
    wr(8'd128, 0); wr(8'd120, 0); settle();
  endtask

  task automatic t_coincident();
    logic [31:0] d;
    wr(8'd120, 32'd7 << 18);
    pins[6] = 1'b1; settle();
    rd(8'd136, d); chk("R8 first edge", d, 32'h40);
    @(negedge clk); pins[6] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 8'd132; bus_wdata = 32'h40; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(8'd136, d); chk("R8 edge beats ack", d, 32'h40);
    wr(8'd132, 32'h40); rd(8'd136, d); chk("R7 plain ack", d, 32'h00);
    wr(8'd120, 0); settle();
  endtask

  task automatic t_frozen();
    logic [31:0] d;
    pins[7] = 1'b1; settle();
    rd(8'd136, d); chk("R11 off while pin moves", d, 32'h00);
    wr(8'd120, 32'd5 << 21); settle();
    rd(8'd136, d); chk("R11 stale edge seen", d, 32'h80);
    wr(8'd132, 32'h80); settle();
    rd(8'd136, d); chk("R11 no repeat", d, 32'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level();
    t_const();
    t_route();
    t_edge();
    t_mask_irq();
    t_coincident();
    t_frozen();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule